// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block is a first-in first-out buffer with separate write and read clocks. Each side keeps its own position counter and learns the other side's position only through a two-flop synchronizer. The flag that one side sees therefore changes a fixed number of its own clock edges after an event on the opposite side. The write side sees a space-available flag, `wr_ready`. The read side sees a data-available flag, `rd_valid`.

A static mode input selects one of two read disciplines. In standard mode, `rd_valid` means the storage array holds at least one word, and a word appears on `rd_data` on the read-clock edge that accepts `rd_en`. In fall-through mode, the read side has an output register that pulls in the head word by itself. `rd_valid` then means that register holds a word, and `rd_en` consumes that word.

A word sitting in the output register counts as removed from the array. In fall-through mode, the block therefore holds one word more than the array depth.

The mode input may change only while reset is asserted. An active-low reset, shared by both domains, clears every counter.

Top module: `dcfifo_flag_sync`

## Requirements
- R1: While reset is low and right after it rises, `rd_valid` reads 0 and `wr_ready` reads 1.
- R2: In both modes, words leave `rd_data` in the order in which they were accepted on the write side, with no loss and no duplication.
- R3: Standard mode: once DEPTH words are held and none has been read, `wr_ready` is 0. A write attempted while `wr_ready` is 0 is dropped and never reaches `rd_data`.
- R4: Fall-through mode: the block accepts DEPTH+1 words before `wr_ready` falls to 0, because the word in the output register no longer occupies the array.
- R5: Standard mode: after a write into an empty FIFO, `rd_valid` is still 0 after the first rising `rclk` edge that follows the write edge. It is 1 after the second such edge.
- R6: After a read frees a slot in a full FIFO, `wr_ready` is still 0 after the first rising `wclk` edge that follows the read edge. It is 1 after the second such edge.
- R7: Fall-through mode: after a write into an empty FIFO, the word is loaded without any `rd_en`. `rd_valid` is 0 after the first and second rising `rclk` edges that follow the write, and it is 1 after the third, with `rd_data` equal to the written word.
- R8: Standard mode: a read attempted while `rd_valid` is 0 has no effect, and `rd_data` keeps its previous value.
- R9: Fall-through mode: while `rd_en` is 0, `rd_valid` stays 1 and `rd_data` stays unchanged once a word has been presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| fwft_mode | input | 1 | 1 = fall-through read discipline, 0 = standard; static outside reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| wr_ready | output | 1 | Space available (input-ready / not-full), write-clock domain |
| rclk | input | 1 | Read clock |
| rd_en | input | 1 | Read request (standard) or consume (fall-through) |
| rd_data | output | DATA_W | Read data / output register |
| rd_valid | output | 1 | Data available (output-ready / not-empty), read-clock domain |

## Verification
The two clocks have unrelated periods, and their edges never coincide. This lets the bench count the exact edge on which each flag changes after an event on the other side.

A flag path with one synchronizer stage too few or too many would show the flag one edge early or late in the latency checks. If the output register is counted as part of the array, fall-through capacity would show up as DEPTH instead of DEPTH+1. If writes are not blocked when full, or reads are not blocked when empty, an extra or stale word would appear in the scoreboard comparison. If the fall-through register reloads while it is not being consumed, `rd_data` would change with no `rd_en`.

// File: rtl/dcfifo_flag_sync.sv
module dcfifo_flag_sync #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              fwft_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rclk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2;
  logic [PW-1:0] wbin_nx;
  logic          do_wr;

  assign wbin_nx  = wbin + 1'b1;
  assign wr_ready = (wgray != {~rg_s2[PW-1:PW-2], rg_s2[PW-3:0]});
  assign do_wr    = wr_en & wr_ready;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (do_wr) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end

  always_ff @(posedge wclk)
    if (do_wr) mem[wbin[ADDR_W-1:0]] <= wr_data;

  logic [PW-1:0] rgray;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
    end

  // ---------------- read domain ----------------
  logic [PW-1:0]     rbin, wg_s1, wg_s2;
  logic [PW-1:0]     rbin_nx;
  logic              mem_has, pop, out_vld;
  logic [DATA_W-1:0] rdata_q;

  assign rbin_nx = rbin + 1'b1;
  assign mem_has = (rgray != wg_s2);
  assign pop     = fwft_mode ? (mem_has & (~out_vld | rd_en)) : (mem_has & rd_en);

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
    end

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      rdata_q <= '0;
    end else if (pop) begin
      rbin    <= rbin_nx;
      rgray   <= rbin_nx ^ (rbin_nx >> 1);
      rdata_q <= mem[rbin[ADDR_W-1:0]];
    end

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n)                    out_vld <= 1'b0;
    else if (!fwft_mode)           out_vld <= 1'b0;
    else if (pop)                  out_vld <= 1'b1;
    else if (rd_en)                out_vld <= 1'b0;

  assign rd_data  = rdata_q;
  assign rd_valid = fwft_mode ? out_vld : mem_has;

  // ---------------- assertions ----------------
  logic [PW-1:0] wlevel, rlevel;
  assign wlevel = wbin - gray2bin(rg_s2);
  assign rlevel = gray2bin(wg_s2) - rbin;

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    wlevel <= PW'(DEPTH));

  assert_blocked_write_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_en && !wr_ready) |=> $stable(wbin));

  assert_no_underflow_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    rlevel <= PW'(DEPTH));

  assert_wgray_step_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_step_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  assert_fwft_hold_R9: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft_mode && rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/dcfifo_flag_sync_tb.sv
`timescale 1ns/100ps
module dcfifo_flag_sync_tb_top;
  localparam int DATA_W = 36;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic wclk = 0, rclk = 0, rst_n = 0, fwft_mode = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_ready, rd_valid;
  logic [DATA_W-1:0] rd_data;

  always #2   wclk = ~wclk;  // 250 MHz, rising edges on whole ns
  always #3.5 rclk = ~rclk;  // rising edges on half ns, never coincident

  dcfifo_flag_sync #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .wclk(wclk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
    .rclk(rclk), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid));

  logic [DATA_W-1:0] sb [$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset(bit mode);
    rst_n = 0; wr_en = 0; rd_en = 0; fwft_mode = mode;
    sb.delete();
    repeat (4) @(negedge wclk);
    rst_n = 1;
    #1;
  endtask

  // driver: pushes expected items
  task automatic write_word(logic [DATA_W-1:0] d, output bit acc);
    @(negedge wclk);
    acc = wr_ready; wr_en = 1; wr_data = d;
    @(negedge wclk);
    wr_en = 0;
    if (acc) sb.push_back(d);
  endtask

  // monitors: pop and compare
  task automatic read_std(output bit ok);
    logic [DATA_W-1:0] e;
    @(negedge rclk);
    ok = rd_valid; rd_en = 1;
    @(negedge rclk);
    rd_en = 0;
    if (ok) begin e = sb.pop_front(); chk("R2", rd_data, e); end
  endtask

  task automatic read_fwft(output bit ok);
    logic [DATA_W-1:0] e;
    @(negedge rclk);
    ok = rd_valid;
    if (ok) begin e = sb.pop_front(); chk("R2", rd_data, e); rd_en = 1; end
    @(negedge rclk);
    rd_en = 0;
  endtask

  task automatic mixed(bit mode, int cnt);
    fork
      begin
        for (int i = 0; i < cnt; i++) begin
          bit a = 0;
          while (!a) write_word(DATA_W'(36'h7000 + i * 3), a);
        end
      end
      begin
        int got = 0;
        while (got < cnt) begin
          bit ok;
          if (mode) read_fwft(ok); else read_std(ok);
          if (ok) got++;
        end
      end
    join
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bit a, ok;
    logic [DATA_W-1:0] prev;

    // ---------- standard mode ----------
    rst_n = 0; fwft_mode = 0;
    #3;
    chk("R1 reset rd_valid", rd_valid, 0);
    chk("R1 reset wr_ready", wr_ready, 1);
    do_reset(0);
    chk("R1 rd_valid after reset", rd_valid, 0);
    chk("R1 wr_ready after reset", wr_ready, 1);

    // R5 empty-flag latency
    @(negedge wclk); wr_en = 1; wr_data = 36'hA1;
    @(posedge wclk); #0.1 wr_en = 0; sb.push_back(36'hA1);
    @(posedge rclk); #0.2 chk("R5 after 1st rclk edge", rd_valid, 0);
    @(posedge rclk); #0.2 chk("R5 after 2nd rclk edge", rd_valid, 1);
    read_std(ok);
    chk("R2 read happened", ok, 1);

    // R8 read while empty
    repeat (3) @(negedge rclk);
    prev = rd_data;
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
    chk("R8 rd_data unchanged", rd_data, prev);
    chk("R8 still empty", rd_valid, 0);

    // R3 fill to full
    for (int i = 0; i < DEPTH; i++) write_word(DATA_W'(36'h100 + i), a);
    chk("R3 accepted count", sb.size(), DEPTH);
    chk("R3 wr_ready low when full", wr_ready, 0);
    write_word(36'hDEAD, a);
    chk("R3 extra write refused", a, 0);
    repeat (6) @(negedge rclk);

    // R6 full-flag latency
    @(negedge rclk); rd_en = 1;
    @(posedge rclk); #0.1 rd_en = 0;
    #0.1 chk("R2 first of full", rd_data, sb.pop_front());
    @(posedge wclk); #0.2 chk("R6 after 1st wclk edge", wr_ready, 0);
    @(posedge wclk); #0.2 chk("R6 after 2nd wclk edge", wr_ready, 1);
    while (sb.size() > 0) read_std(ok);
    repeat (6) @(negedge rclk);
    chk("R3 dropped word absent", rd_valid, 0);

    mixed(0, 40);
    chk("R2 std scoreboard drained", sb.size(), 0);

    // ---------- fall-through mode ----------
    do_reset(1);
    chk("R1 fwft rd_valid after reset", rd_valid, 0);
    chk("R1 fwft wr_ready after reset", wr_ready, 1);

    @(negedge wclk); wr_en = 1; wr_data = 36'hB7;
    @(posedge wclk); #0.1 wr_en = 0; sb.push_back(36'hB7);
    @(posedge rclk); #0.2 chk("R7 after 1st rclk edge", rd_valid, 0);
    @(posedge rclk); #0.2 chk("R7 after 2nd rclk edge", rd_valid, 0);
    @(posedge rclk); #0.2 chk("R7 after 3rd rclk edge", rd_valid, 1);
    chk("R7 word presented", rd_data, 36'hB7);

    repeat (5) @(negedge rclk);
    chk("R9 valid held", rd_valid, 1);
    chk("R9 data held", rd_data, 36'hB7);
    read_fwft(ok);
    chk("R9 consumed", ok, 1);
    repeat (4) @(negedge rclk);
    chk("R9 empty after consume", rd_valid, 0);

    // R4 capacity DEPTH+1
    write_word(36'h200, a);
    repeat (20) @(negedge wclk);
    for (int i = 1; i <= DEPTH + 1; i++) write_word(DATA_W'(36'h200 + i), a);
    repeat (10) @(negedge wclk);
    chk("R4 words held", sb.size(), DEPTH + 1);
    chk("R4 wr_ready low", wr_ready, 0);
    while (sb.size() > 0) read_fwft(ok);
    repeat (6) @(negedge rclk);
    chk("R4 drained", rd_valid, 0);

    mixed(1, 40);
    chk("R2 fwft scoreboard drained", sb.size(), 0);

    summary();
  end
endmodule